// File: doc/BRIEF.md
# Conversion Result Buffer with Data-Ready Flag

This block takes each finished conversion word from a converter's decimation filter, applies a digital gain multiply, and holds the result in an output register. It also drives an active-low data-ready flag that tells a serial reader a result is waiting. The gain is chosen by a 3-bit code. The four upper codes multiply the word by a power of two and clamp it to the signed full-scale limits, so the value never wraps.

A reader marks the start and the end of its access with single-cycle `rd_start` and `rd_done` pulses. While a read is open, the output register is frozen. A result that arrives during the read goes into one spare slot, and a later arrival replaces the slot's content. When the read closes, the slot's result (if any) moves into the output register and the flag stays low. If the slot is empty, the flag returns high. A standby input drops incoming results and forces the flag high.

All outputs are registered. Each change appears after the clock edge at which its cause is sampled.

Top module: `conv_result_buffer`

## Requirements
- R1: After reset, `drdy_n` is 1, `dout` is 0 and no read is open.
- R2: With no read open and standby low, a `conv_valid` pulse loads the scaled word into `dout` and drives `drdy_n` to 0 one cycle later. This replaces any unread result.
- R3: Gain codes 0 to 3 pass the signed input word through unchanged.
- R4: Gain codes 4, 5, 6 and 7 multiply the signed word by 2, 4, 8 and 16 respectively.
- R5: A scaled value above 2^(W-1)-1 becomes 2^(W-1)-1, and a value below -2^(W-1) becomes -2^(W-1).
- R6: `rd_start` opens a read only when a result is held (`drdy_n` low). While the read is open, `dout` does not change and `drdy_n` stays 0 until `rd_done`.
- R7: A result arriving during an open read goes to the spare slot. On `rd_done`, that result moves into `dout` and `drdy_n` stays 0. If a new result arrives in the same cycle as `rd_done`, the new result goes to `dout` instead.
- R8: A further result arriving while the spare slot is occupied overwrites the slot, so the newest result is what moves up on `rd_done`.
- R9: On `rd_done` with an empty slot, `drdy_n` returns to 1 and `dout` keeps its value.
- R10: While `standby` is 1, `drdy_n` is 1 from the next cycle and `conv_valid` pulses are dropped. After standby ends, `drdy_n` again reflects whether a result is held.
- R11: `rd_start` with no result held, and `rd_done` with no read open, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Halts updates and forces the ready flag high |
| gain_code | input | 3 | Gain select; codes 4..7 apply a digital multiply |
| conv_valid | input | 1 | Strobe for a new filter word |
| conv_data | input | W | Signed filter word |
| rd_start | input | 1 | Reader begins reading `dout` |
| rd_done | input | 1 | Reader has finished reading `dout` |
| dout | output | W | Output result register |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
The hardest state to reach is a read held open across two arrivals. The first arrival fills the spare slot and the second overwrites it, so the slot's content is hidden behind a frozen output. The stimulus opens a read, pushes two distinct words, and checks that `dout` and `drdy_n` do not move. It then closes the read and expects the second word to appear. The gain path is swept over every code with values chosen at and beyond both saturation edges.

// File: rtl/conv_result_buffer.sv
module conv_result_buffer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         standby,
  input  logic [2:0]   gain_code,
  input  logic         conv_valid,
  input  logic [W-1:0] conv_data,
  input  logic         rd_start,
  input  logic         rd_done,
  output logic [W-1:0] dout,
  output logic         drdy_n
);
  localparam int XW = W + 5;
  localparam logic signed [XW-1:0] MAXV = {{6{1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] MINV = {{6{1'b1}}, {(W-1){1'b0}}};

  logic [2:0]           shamt;
  logic signed [XW-1:0] ext, shifted;
  logic [W-1:0]         scaled;

  assign shamt   = gain_code[2] ? {1'b0, gain_code[1:0]} + 3'd1 : 3'd0;
  assign ext     = {{5{conv_data[W-1]}}, conv_data};
  assign shifted = ext <<< shamt;
  assign scaled  = (shifted > MAXV) ? MAXV[W-1:0] :
                   (shifted < MINV) ? MINV[W-1:0] : shifted[W-1:0];

  logic         out_full, reading, buf_full;
  logic [W-1:0] buf_q;
  logic         of_n, rd_n, bf_n;
  logic [W-1:0] dout_n, buf_n;
  logic         take;

  assign take = conv_valid & ~standby;

  always_comb begin
    of_n   = out_full;
    rd_n   = reading;
    bf_n   = buf_full;
    dout_n = dout;
    buf_n  = buf_q;
    if (reading && rd_done) begin
      rd_n = 1'b0;
      if (buf_full) begin
        dout_n = buf_q;
        bf_n   = 1'b0;
      end else begin
        of_n = 1'b0;
      end
    end else if (!reading && rd_start && out_full) begin
      rd_n = 1'b1;
    end
    if (take) begin
      if (rd_n) begin
        buf_n = scaled;
        bf_n  = 1'b1;
      end else begin
        dout_n = scaled;
        of_n   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_full <= 1'b0;
      reading  <= 1'b0;
      buf_full <= 1'b0;
      buf_q    <= '0;
      dout     <= '0;
      drdy_n   <= 1'b1;
    end else begin
      out_full <= of_n;
      reading  <= rd_n;
      buf_full <= bf_n;
      buf_q    <= buf_n;
      dout     <= dout_n;
      drdy_n   <= standby | ~of_n;
    end
  end
endmodule

module conv_result_buffer_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         standby,
  input logic         conv_valid,
  input logic         rd_done,
  input logic         reading,
  input logic         buf_full,
  input logic [W-1:0] dout,
  input logic         drdy_n
);
  AST_STANDBY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> drdy_n); // R10
  AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && !standby && !reading) |=> !drdy_n); // R2
  AST_READ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !rd_done) |=> $stable(dout)); // R6
  AST_SLOT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> reading); // R7
  AST_SLOT_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && rd_done && buf_full && !standby) |=> !drdy_n); // R7
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && rd_done && !buf_full && !conv_valid) |=> drdy_n); // R9
endmodule

bind conv_result_buffer conv_result_buffer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .conv_valid(conv_valid),
  .rd_done(rd_done), .reading(reading), .buf_full(buf_full),
  .dout(dout), .drdy_n(drdy_n)
);

// File: tb/sim_conv_result_buffer.sv
module sim_conv_result_buffer;
  localparam int W = 24;
  logic clk = 1'b0, rst_n = 1'b0, standby = 1'b0;
  logic [2:0] gain_code = '0;
  logic conv_valid = 1'b0, rd_start = 1'b0, rd_done = 1'b0;
  logic [W-1:0] conv_data = '0;
  logic [W-1:0] dout;
  logic drdy_n;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  conv_result_buffer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .standby(standby), .gain_code(gain_code),
    .conv_valid(conv_valid), .conv_data(conv_data), .rd_start(rd_start),
    .rd_done(rd_done), .dout(dout), .drdy_n(drdy_n)
  );

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx(logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint expect_scaled(longint v, int code);
    longint mult = (code >= 4) ? (longint'(1) << (code - 3)) : 1;
    longint r = v * mult;
    longint mx = (longint'(1) << (W - 1)) - 1;
    longint mn = -(longint'(1) << (W - 1));
    if (r > mx) return mx;
    if (r < mn) return mn;
    return r;
  endfunction

  task automatic step(bit v, longint d, bit s, bit e);
    conv_valid = v; conv_data = d[W-1:0]; rd_start = s; rd_done = e;
    @(negedge clk);
    conv_valid = 0; rd_start = 0; rd_done = 0;
  endtask

  initial begin
    longint vals[12];
    vals = '{0, 1, -1, 12345, -12345, 524288, -524288, 1048579,
             8388607, -8388608, 4194304, -4194305};
    @(negedge clk); @(negedge clk);
    chk("R1 drdy_n", drdy_n, 1);
    chk("R1 dout", sx(dout), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: rd_start while empty ignored, so next word loads dout directly
    step(0, 0, 1, 0);
    step(1, 777, 0, 0);
    chk("R11 start ignored dout", sx(dout), 777);
    chk("R11 drdy_n", drdy_n, 0);
    step(0, 0, 0, 1);
    chk("R11 done ignored drdy_n", drdy_n, 0);
    step(1, 888, 0, 0);
    chk("R11 done ignored dout", sx(dout), 888);

    // R2 R3 R4 R5: gain sweep
    for (int c = 0; c < 8; c++) begin
      gain_code = c[2:0];
      for (int i = 0; i < 12; i++) begin
        step(1, vals[i], 0, 0);
        chk(c < 4 ? "R3 unity gain" : "R4 R5 gain/saturation",
            sx(dout), expect_scaled(vals[i], c));
        chk("R2 drdy_n", drdy_n, 0);
      end
    end
    gain_code = 3'd0;

    // R6 R7 R8 R9: read protection
    step(1, 100, 0, 0);
    step(0, 0, 1, 0);
    chk("R6 open read drdy_n", drdy_n, 0);
    step(1, 200, 0, 0);
    chk("R6 frozen dout", sx(dout), 100);
    chk("R6 drdy_n held", drdy_n, 0);
    step(1, 300, 0, 0);
    chk("R8 frozen dout", sx(dout), 100);
    step(0, 0, 0, 1);
    chk("R8 newest moves up", sx(dout), 300);
    chk("R7 drdy_n stays low", drdy_n, 0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 1);
    chk("R9 drdy_n high", drdy_n, 1);
    chk("R9 dout kept", sx(dout), 300);

    // R7: single buffered result, then done with simultaneous arrival
    step(1, 400, 0, 0);
    step(0, 0, 1, 0);
    step(1, 500, 0, 0);
    step(0, 0, 0, 1);
    chk("R7 slot moves up", sx(dout), 500);
    chk("R7 drdy_n", drdy_n, 0);
    step(0, 0, 1, 0);
    step(1, 600, 0, 1);
    chk("R7 arrival with done", sx(dout), 600);
    chk("R7 drdy_n arrival with done", drdy_n, 0);

    // R10: standby
    standby = 1'b1;
    @(negedge clk);
    chk("R10 drdy_n forced", drdy_n, 1);
    step(1, 999, 0, 0);
    chk("R10 word dropped", sx(dout), 600);
    chk("R10 drdy_n still high", drdy_n, 1);
    standby = 1'b0;
    @(negedge clk);
    chk("R10 restored drdy_n", drdy_n, 0);
    chk("R10 dout kept", sx(dout), 600);
    step(1, 700, 0, 0);
    chk("R10 update resumes", sx(dout), 700);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule